// File: doc/BRIEF.md
# Host Bit-Serial Memory Sequencer

This block sits on the host side of a single-bit memory bus. It turns one request into a string of individual bus cycles on three active-low strobes: chip-enable, output-enable and write-enable. Each bus cycle carries a single data bit. A read request names a start address and a byte count. The block first sends the framing pattern that resynchronises the memory and then shifts out the address. It gathers the returned bits into bytes, which it presents one at a time, and it closes the read with a terminating write.

A write request loads up to one 64-byte page. The block pulls the page bytes one by one from the requester, sends the commit pattern, and then polls the data line until the memory reports that it is no longer busy. Polling gives up after a parameterised number of attempts. Setup, strobe width, recovery and sampling point are all counted in clocks and set by parameters. The data line is split into an output, an output enable and an input. It is sampled through a configurable synchroniser at a fixed clock offset into the read strobe.

Top module: `bitser_mem_seq`

## Requirements
- R1: While and after rst_n is low, bus_ce_n, bus_oe_n and bus_we_n are high, bus_doe is low, req_ready is high, and done, rd_valid, timeout_err and wr_take are low.
- R2: Every accepted request first issues three bus cycles in this order: a read cycle, a write cycle carrying 0, and a read cycle.
- R3: Next come 16 write cycles that carry req_addr most significant bit first. No read cycle falls between them.
- R4: A read request with req_len = N-1 (N from 1 to 64) then issues 8N read cycles. Each group of eight is assembled most significant bit first and appears on rd_byte during a one-clock rd_valid pulse, in increasing address order. One write cycle carrying 1 follows, and then a done pulse.
- R5: A write request with req_len = N-1 then issues 8N write cycles, most significant bit first. Each byte is taken from wr_byte in the clock in which wr_take is high, once per byte. The commit pattern follows: a read, a write carrying 1, and a read.
- R6: After the commit pattern, read cycles repeat until one of them samples 1 on bus_din. The block then gives a done pulse with timeout_err low.
- R7: If POLL_MAX polls in a row all sample 0, polling stops. done pulses, and timeout_err is high in the same clock.
- R8: bus_we_n and bus_oe_n are never both low while bus_ce_n is low. bus_doe is high only while bus_ce_n is low and bus_oe_n is high.
- R9: Every strobe stays low for exactly LOW_CLKS clocks. Before each strobe falls, bus_ce_n has been low with both strobes high for at least SETUP_CLKS clocks. Between bus cycles, bus_ce_n stays high for at least REC_CLKS clocks. During a write cycle, bus_doe stays high until after write-enable rises.
- R10: req_ready is high only when the block is idle. A req_valid that arrives while the block is busy is ignored. The bus stays quiet (bus_ce_n high) whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = page write, 0 = read |
| req_addr | input | 16 | Start address |
| req_len | input | LEN_W (6) | Byte count minus one |
| wr_byte | input | 8 | Next page byte, consumed when wr_take is high |
| wr_take | output | 1 | Pulse: wr_byte is consumed at this clock edge |
| rd_valid | output | 1 | Pulse: rd_byte holds a returned byte |
| rd_byte | output | 8 | Returned byte |
| done | output | 1 | Pulse: request finished |
| timeout_err | output | 1 | With done: busy polling hit its limit |
| bus_ce_n | output | 1 | Bus chip-enable, active low |
| bus_oe_n | output | 1 | Bus output-enable (read strobe), active low |
| bus_we_n | output | 1 | Bus write-enable (write strobe), active low |
| bus_dout | output | 1 | Data bit driven in write cycles |
| bus_doe | output | 1 | Drive enable for bus_dout |
| bus_din | input | 1 | Data bit returned by the memory |

## Verification
Reads are swept over byte counts of 1, 2, 3 and the full 64, at start addresses chosen so that all-zero, all-one and alternating address bits reach the bus. This separates errors in address bit order from errors in data bit order and byte order. Page writes run at 1, 3 and 64 bytes with busy periods of zero and several polls, which shows whether the commit pattern and the byte pull are counted correctly. Two busy lengths sit on either side of the poll limit, one limit-1 and one far over it, to tell a clean finish from a timeout. A request presented while a transfer is under way checks that nothing is started twice.

// File: rtl/bitser_pkg.sv
package bitser_pkg;

  localparam int ADDR_BITS = 16;
  localparam int DATA_BITS = 8;

  // Request-level sequencing phase
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,    // read / write 0 / read framing
    ST_ADDR,   // address bits, MSB first
    ST_RDAT,   // returned data bits
    ST_RTRM,   // terminating write of 1
    ST_WDAT,   // page data bits
    ST_CMIT,   // read / write 1 / read commit
    ST_POLL    // busy polling
  } seq_st_e;

  // Single bus cycle phase
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STRB,
    PH_HOLD,
    PH_RECV
  } bus_ph_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bitser_cycle.sv
module bitser_cycle
  import bitser_pkg::*;
#(
  parameter int SETUP_CLKS  = 3,
  parameter int LOW_CLKS    = 7,
  parameter int REC_CLKS    = 17,
  parameter int SAMPLE_OFS  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic go_wr,
  input  logic go_bit,
  input  logic bus_din,
  output logic fin,
  output logic rbit,
  output logic bus_ce_n,
  output logic bus_oe_n,
  output logic bus_we_n,
  output logic bus_dout,
  output logic bus_doe
);

  localparam int MAXC  = max3(SETUP_CLKS, LOW_CLKS, REC_CLKS);
  localparam int CNT_W = $clog2(MAXC + 1);

  // Input synchroniser, depth chosen by parameter
  logic din_s;
  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign din_s = bus_din;
    end else begin : g_sync
      logic stg [SYNC_STAGES];
      for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_stg
        if (k == 0) begin : g_first
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= 1'b1;
            else        stg[k] <= bus_din;
          end
        end else begin : g_next
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= 1'b1;
            else        stg[k] <= stg[k-1];
          end
        end
      end
      assign din_s = stg[SYNC_STAGES-1];
    end
  endgenerate

  bus_ph_e          ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;
  logic             bit_q, bit_d;
  logic             rbit_q, rbit_d;
  logic             ce_n_q, oe_n_q, we_n_q, doe_q;
  logic             act_d;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    wr_d   = wr_q;
    bit_d  = bit_q;
    rbit_d = rbit_q;
    fin    = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (go) begin
          ph_d  = PH_SETUP;
          cnt_d = '0;
          wr_d  = go_wr;
          bit_d = go_bit;
        end
      end
      PH_SETUP: begin
        if (cnt_q == CNT_W'(SETUP_CLKS - 1)) begin
          ph_d  = PH_STRB;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_STRB: begin
        if (!wr_q && (cnt_q == CNT_W'(SAMPLE_OFS))) rbit_d = din_s;
        if (cnt_q == CNT_W'(LOW_CLKS - 1)) begin
          ph_d  = PH_HOLD;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_HOLD: begin
        ph_d = PH_RECV;
      end
      PH_RECV: begin
        if (cnt_q == CNT_W'(REC_CLKS - 1)) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
          fin   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  assign act_d = (ph_d == PH_SETUP) || (ph_d == PH_STRB) || (ph_d == PH_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      bit_q  <= 1'b0;
      rbit_q <= 1'b1;
      ce_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      we_n_q <= 1'b1;
      doe_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      wr_q   <= wr_d;
      bit_q  <= bit_d;
      rbit_q <= rbit_d;
      // strobe pins decoded from the next phase so the pins come straight from flops
      ce_n_q <= !act_d;
      oe_n_q <= !((ph_d == PH_STRB) && !wr_d);
      we_n_q <= !((ph_d == PH_STRB) && wr_d);
      doe_q  <= act_d && wr_d;
    end
  end

  assign rbit     = rbit_q;
  assign bus_ce_n = ce_n_q;
  assign bus_oe_n = oe_n_q;
  assign bus_we_n = we_n_q;
  assign bus_dout = bit_q;
  assign bus_doe  = doe_q;

endmodule

// File: rtl/bitser_ctrl.sv
module bitser_ctrl
  import bitser_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int POLL_MAX  = 4096
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic                           req_write,
  input  logic [ADDR_BITS-1:0]           req_addr,
  input  logic [$clog2(MAX_BYTES)-1:0]   req_len,
  input  logic [DATA_BITS-1:0]           wr_byte,
  output logic                           wr_take,
  output logic                           rd_valid,
  output logic [DATA_BITS-1:0]           rd_byte,
  output logic                           done,
  output logic                           timeout_err,
  input  logic                           fin,
  input  logic                           rbit,
  output logic                           go,
  output logic                           go_wr,
  output logic                           go_bit
);

  localparam int LEN_W  = $clog2(MAX_BYTES);
  localparam int POLL_W = $clog2(POLL_MAX + 1);
  localparam int STEP_W = $clog2(ADDR_BITS) + 1;
  localparam logic [STEP_W-1:0] ADDR_LAST = STEP_W'(ADDR_BITS - 1);
  localparam logic [STEP_W-1:0] BIT_LAST  = STEP_W'(DATA_BITS - 1);
  localparam logic [STEP_W-1:0] PAT_LAST  = STEP_W'(2);

  seq_st_e               st_q, st_d;
  logic [STEP_W-1:0]     step_q, step_d;
  logic [LEN_W-1:0]      byte_q, byte_d;
  logic [LEN_W-1:0]      len_q, len_d;
  logic [ADDR_BITS-1:0]  addr_q, addr_d;
  logic                  wr_q, wr_d;
  logic [DATA_BITS-1:0]  sh_q, sh_d;
  logic                  wait_q, wait_d;
  logic [POLL_W-1:0]     poll_q, poll_d;
  logic                  done_q, done_d;
  logic                  err_q, err_d;
  logic                  rdv_q, rdv_d;

  always_comb begin
    st_d    = st_q;
    step_d  = step_q;
    byte_d  = byte_q;
    len_d   = len_q;
    addr_d  = addr_q;
    wr_d    = wr_q;
    sh_d    = sh_q;
    wait_d  = wait_q;
    poll_d  = poll_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    rdv_d   = 1'b0;
    wr_take = 1'b0;
    go      = 1'b0;
    go_wr   = 1'b0;
    go_bit  = 1'b0;
    req_ready = (st_q == ST_IDLE);

    // kind and bit of the cycle this phase issues
    case (st_q)
      ST_RST:  go_wr = (step_q == STEP_W'(1));
      ST_ADDR: begin go_wr = 1'b1; go_bit = addr_q[ADDR_BITS-1]; end
      ST_RTRM: begin go_wr = 1'b1; go_bit = 1'b1; end
      ST_WDAT: begin go_wr = 1'b1; go_bit = sh_q[DATA_BITS-1]; end
      ST_CMIT: begin go_wr = (step_q == STEP_W'(1)); go_bit = 1'b1; end
      default: begin go_wr = 1'b0; go_bit = 1'b0; end
    endcase

    if ((st_q != ST_IDLE) && !wait_q) begin
      go     = 1'b1;
      wait_d = 1'b1;
    end

    if (st_q == ST_IDLE) begin
      if (req_valid) begin
        st_d   = ST_RST;
        step_d = '0;
        byte_d = '0;
        len_d  = req_len;
        addr_d = req_addr;
        wr_d   = req_write;
        wait_d = 1'b0;
      end
    end else if (wait_q && fin) begin
      wait_d = 1'b0;
      step_d = step_q + 1'b1;
      case (st_q)
        ST_RST: begin
          if (step_q == PAT_LAST) begin
            st_d   = ST_ADDR;
            step_d = '0;
          end
        end
        ST_ADDR: begin
          addr_d = addr_q << 1;
          if (step_q == ADDR_LAST) begin
            step_d = '0;
            if (wr_q) begin
              st_d    = ST_WDAT;
              wr_take = 1'b1;
              sh_d    = wr_byte;
            end else begin
              st_d = ST_RDAT;
            end
          end
        end
        ST_RDAT: begin
          sh_d = {sh_q[DATA_BITS-2:0], rbit};
          if (step_q == BIT_LAST) begin
            step_d = '0;
            rdv_d  = 1'b1;
            if (byte_q == len_q) st_d = ST_RTRM;
            else                 byte_d = byte_q + 1'b1;
          end
        end
        ST_RTRM: begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
        ST_WDAT: begin
          sh_d = sh_q << 1;
          if (step_q == BIT_LAST) begin
            step_d = '0;
            if (byte_q == len_q) begin
              st_d = ST_CMIT;
            end else begin
              byte_d  = byte_q + 1'b1;
              wr_take = 1'b1;
              sh_d    = wr_byte;
            end
          end
        end
        ST_CMIT: begin
          if (step_q == PAT_LAST) begin
            st_d   = ST_POLL;
            step_d = '0;
            poll_d = '0;
          end
        end
        ST_POLL: begin
          if (rbit) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else if (poll_q == POLL_W'(POLL_MAX - 1)) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            err_d  = 1'b1;
          end else begin
            poll_d = poll_q + 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      byte_q <= '0;
      len_q  <= '0;
      addr_q <= '0;
      wr_q   <= 1'b0;
      sh_q   <= '0;
      wait_q <= 1'b0;
      poll_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rdv_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      byte_q <= byte_d;
      len_q  <= len_d;
      addr_q <= addr_d;
      wr_q   <= wr_d;
      sh_q   <= sh_d;
      wait_q <= wait_d;
      poll_q <= poll_d;
      done_q <= done_d;
      err_q  <= err_d;
      rdv_q  <= rdv_d;
    end
  end

  assign rd_valid    = rdv_q;
  assign rd_byte     = sh_q;
  assign done        = done_q;
  assign timeout_err = err_q;

endmodule

// File: rtl/bitser_mem_seq.sv
module bitser_mem_seq
  import bitser_pkg::*;
#(
  parameter int SETUP_CLKS  = 3,
  parameter int LOW_CLKS    = 7,
  parameter int REC_CLKS    = 17,
  parameter int SAMPLE_OFS  = 5,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_BYTES   = 64,
  parameter int POLL_MAX    = 4096,
  localparam int LEN_W      = $clog2(MAX_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_byte,
  output logic             wr_take,
  output logic             rd_valid,
  output logic [7:0]       rd_byte,
  output logic             done,
  output logic             timeout_err,
  output logic             bus_ce_n,
  output logic             bus_oe_n,
  output logic             bus_we_n,
  output logic             bus_dout,
  output logic             bus_doe,
  input  logic             bus_din
);

  logic go, go_wr, go_bit, fin, rbit;

  bitser_ctrl #(
    .MAX_BYTES (MAX_BYTES),
    .POLL_MAX  (POLL_MAX)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .wr_byte     (wr_byte),
    .wr_take     (wr_take),
    .rd_valid    (rd_valid),
    .rd_byte     (rd_byte),
    .done        (done),
    .timeout_err (timeout_err),
    .fin         (fin),
    .rbit        (rbit),
    .go          (go),
    .go_wr       (go_wr),
    .go_bit      (go_bit)
  );

  bitser_cycle #(
    .SETUP_CLKS  (SETUP_CLKS),
    .LOW_CLKS    (LOW_CLKS),
    .REC_CLKS    (REC_CLKS),
    .SAMPLE_OFS  (SAMPLE_OFS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_cycle (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .go_wr    (go_wr),
    .go_bit   (go_bit),
    .bus_din  (bus_din),
    .fin      (fin),
    .rbit     (rbit),
    .bus_ce_n (bus_ce_n),
    .bus_oe_n (bus_oe_n),
    .bus_we_n (bus_we_n),
    .bus_dout (bus_dout),
    .bus_doe  (bus_doe)
  );

endmodule

// File: rtl/bitser_chk.sv
module bitser_chk #(
  parameter int LOW_CLKS = 7
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic wr_take,
  input logic done,
  input logic timeout_err,
  input logic bus_ce_n,
  input logic bus_oe_n,
  input logic bus_we_n,
  input logic bus_doe
);

  localparam int W = $clog2(LOW_CLKS + 2);

  logic         strobe_low;
  logic [W-1:0] low_cnt;

  assign strobe_low = !bus_we_n || !bus_oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= '0;
    else if (strobe_low) low_cnt <= low_cnt + 1'b1;
    else                 low_cnt <= '0;
  end

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ce_n |-> (bus_we_n || bus_oe_n));

  // R8
  drive_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (bus_oe_n && !bus_ce_n));

  // R9
  strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_we_n) || $fell(bus_oe_n)) |-> $past(!bus_ce_n));

  // R9
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe_low) && !strobe_low) |-> (low_cnt == W'(LOW_CLKS)));

  // R9
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we_n) |-> (!bus_ce_n && bus_doe));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_ce_n);

  // R5
  take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> !req_ready);

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> done);

endmodule

bind bitser_mem_seq bitser_chk #(.LOW_CLKS(LOW_CLKS)) u_bitser_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .wr_take     (wr_take),
  .done        (done),
  .timeout_err (timeout_err),
  .bus_ce_n    (bus_ce_n),
  .bus_oe_n    (bus_oe_n),
  .bus_we_n    (bus_we_n),
  .bus_doe     (bus_doe)
);

// File: tb/test_bitser_mem_seq.sv
`timescale 1ns/1ps
module test_bitser_mem_seq;

  localparam int SETUP = 1;
  localparam int LOWC  = 3;
  localparam int REC   = 1;
  localparam int SAMP  = 2;
  localparam int SYNC  = 1;
  localparam int POLLM = 20;
  localparam int MAXB  = 64;
  localparam int LEN_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_write = 1'b0;
  logic [15:0]      req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0]       wr_byte;
  logic             wr_take;
  logic             rd_valid;
  logic [7:0]       rd_byte;
  logic             done;
  logic             timeout_err;
  logic             bus_ce_n, bus_oe_n, bus_we_n, bus_dout, bus_doe;
  logic             bus_din;

  always #2 clk = ~clk;

  bitser_mem_seq #(
    .SETUP_CLKS(SETUP), .LOW_CLKS(LOWC), .REC_CLKS(REC), .SAMPLE_OFS(SAMP),
    .SYNC_STAGES(SYNC), .MAX_BYTES(MAXB), .POLL_MAX(POLLM)
  ) i_bitser_mem_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .wr_byte(wr_byte), .wr_take(wr_take), .rd_valid(rd_valid), .rd_byte(rd_byte),
    .done(done), .timeout_err(timeout_err), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
  );

  int nchk = 0;
  int nerr = 0;

  // transaction model state
  bit          t_wr = 1'b0;
  logic [15:0] t_addr = '0;
  int          t_n = 1;
  int          t_busy = 0;
  int          n_log = 0;
  bit          lk [0:1023];
  bit          lb [0:1023];
  logic [7:0]  rx [0:127];
  int          nrx = 0;
  int          widx = 0;
  bit          got_err;

  // timing monitors
  int ce_hi = 0, strb_lo = 0, pre = 0;
  int v_excl = 0, v_dir = 0, v_rec = 0, v_low = 0, v_setup = 0;
  bit seen = 1'b0;

  function automatic logic [7:0] memf(input logic [15:0] a);
    logic [15:0] p;
    p = a * 16'd37;
    return p[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic din_f(input int n);
    int base;
    int k;
    int j;
    logic [7:0] d;
    base = 19 + 8 * t_n;
    din_f = 1'b1;
    if (!t_wr && n >= 19 && n < base) begin
      k = (n - 19) / 8;
      j = (n - 19) % 8;
      d = memf(t_addr + 16'(k));
      din_f = d[7 - j];
    end
    if (t_wr && n >= base + 3 && n < base + 3 + t_busy) din_f = 1'b0;
  endfunction

  always_comb bus_din = din_f(n_log);
  always_comb wr_byte = memf(t_addr + 16'(widx));

  always @(posedge clk) if (wr_take) widx <= widx + 1;

  always @(posedge bus_we_n) begin
    if (bus_ce_n === 1'b0) begin
      if (n_log < 1024) begin lk[n_log] = 1'b1; lb[n_log] = bus_dout; end
      n_log++;
    end
  end

  always @(posedge bus_oe_n) begin
    if (bus_ce_n === 1'b0) begin
      if (n_log < 1024) begin lk[n_log] = 1'b0; lb[n_log] = bus_din; end
      n_log++;
    end
  end

  always @(negedge clk) begin
    if (rd_valid && nrx < 128) begin
      rx[nrx] = rd_byte;
      nrx++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic sl;
      sl = !bus_we_n || !bus_oe_n;
      if (!bus_ce_n && !bus_we_n && !bus_oe_n) v_excl++;
      if (bus_doe && (bus_ce_n || !bus_oe_n)) v_dir++;
      if (bus_ce_n) ce_hi++;
      else begin
        if (seen && ce_hi > 0 && ce_hi < REC) v_rec++;
        seen = 1'b1;
        ce_hi = 0;
      end
      if (sl) begin
        if (strb_lo == 0 && pre < SETUP) v_setup++;
        strb_lo++;
      end else begin
        if (strb_lo > 0 && strb_lo != LOWC) v_low++;
        strb_lo = 0;
      end
      if (bus_ce_n) pre = 0;
      else if (!sl) pre++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  // expected kind (1 = write) and bit of bus cycle i; cmp = bit is meaningful
  task automatic exp_cycle(input int i, output bit ek, output bit eb, output bit cmp);
    int base;
    logic [7:0] d;
    base = 19 + 8 * t_n;
    ek = 1'b0; eb = 1'b0; cmp = 1'b1;
    if (i == 0 || i == 2) begin ek = 1'b0; cmp = 1'b0; end
    else if (i == 1) begin ek = 1'b1; eb = 1'b0; end
    else if (i < 19) begin ek = 1'b1; eb = t_addr[15 - (i - 3)]; end
    else if (!t_wr) begin
      if (i < base) begin ek = 1'b0; cmp = 1'b0; end
      else begin ek = 1'b1; eb = 1'b1; end
    end else if (i < base) begin
      ek = 1'b1;
      d = memf(t_addr + 16'((i - 19) / 8));
      eb = d[7 - ((i - 19) % 8)];
    end else if (i == base + 1) begin ek = 1'b1; eb = 1'b1; end
    else begin ek = 1'b0; cmp = 1'b0; end
  endtask

  task automatic run_req(input bit wr, input logic [15:0] a, input int n, input int busy);
    t_wr = wr; t_addr = a; t_n = n; t_busy = busy;
    n_log = 0; nrx = 0; widx = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = LEN_W'(n - 1);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    got_err = timeout_err;
    @(negedge clk);
  endtask

  task automatic verify(input string body_req);
    int base, exp_n, b_rst, b_adr, b_body;
    bit ek, eb, cmp;
    base = 19 + 8 * t_n;
    if (t_wr) exp_n = base + 3 + ((t_busy < POLLM) ? t_busy + 1 : POLLM);
    else      exp_n = base + 1;
    chk(body_req, "bus cycle count", n_log, exp_n);
    b_rst = -1; b_adr = -1; b_body = -1;
    for (int i = 0; i < exp_n && i < n_log; i++) begin
      exp_cycle(i, ek, eb, cmp);
      if (lk[i] !== ek || (cmp && lb[i] !== eb)) begin
        if (i < 3) begin if (b_rst < 0) b_rst = i; end
        else if (i < 19) begin if (b_adr < 0) b_adr = i; end
        else if (b_body < 0) b_body = i;
      end
    end
    chk("R2", "reset pattern first bad cycle", b_rst, -1);
    chk("R3", "address first bad cycle", b_adr, -1);
    chk(body_req, "data/tail first bad cycle", b_body, -1);
  endtask

  task automatic do_read(input logic [15:0] a, input int n);
    int bad;
    run_req(1'b0, a, n, 0);
    verify("R4");
    chk("R4", "bytes delivered", nrx, n);
    bad = 0;
    for (int k = 0; k < n && k < nrx; k++) if (rx[k] !== memf(a + 16'(k))) bad++;
    chk("R4", "wrong bytes", bad, 0);
    chk("R4", "error flag on read", int'(got_err), 0);
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input int busy);
    run_req(1'b1, a, n, busy);
    verify(busy < POLLM ? "R5" : "R7");
    chk("R5", "bytes taken", widx, n);
    if (busy < POLLM) chk("R6", "timeout flag clear", int'(got_err), 0);
    else              chk("R7", "timeout flag set", int'(got_err), 1);
  endtask

  initial begin
    int keep;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "ce_n in reset", int'(bus_ce_n), 1);
    chk("R1", "oe_n in reset", int'(bus_oe_n), 1);
    chk("R1", "we_n in reset", int'(bus_we_n), 1);
    chk("R1", "doe in reset", int'(bus_doe), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "ready after reset", int'(req_ready), 1);
    chk("R1", "done/rd_valid/err/take after reset",
        int'({done, rd_valid, timeout_err, wr_take}), 0);

    // R4 reads
    do_read(16'h0000, 1);
    do_read(16'hFFFF, 2);
    do_read(16'hA5C3, 3);
    do_read(16'h1234, 64);

    // R5 / R6 writes
    do_write(16'h0040, 1, 0);
    do_write(16'h1FC0, 3, 5);
    do_write(16'h8000, 64, 2);
    // R6 boundary: busy for POLLM-1 polls, done on the last allowed poll
    do_write(16'h0100, 2, POLLM - 1);
    // R7 timeout
    do_write(16'h0200, 1, 1000);

    // R10 request while busy is ignored
    t_wr = 1'b0; t_addr = 16'h0300; t_n = 1; t_busy = 0;
    n_log = 0; nrx = 0; widx = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0300; req_len = '0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk("R10", "ready while busy", int'(req_ready), 0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'hFFFF; req_len = 6'd5;
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    verify("R10");
    keep = n_log;
    repeat (100) @(negedge clk);
    chk("R10", "no bus cycles after done", n_log, keep);
    chk("R10", "ce_n idle high", int'(bus_ce_n), 1);

    // R8 / R9 bus rules seen over the whole run
    chk("R8", "strobe overlap samples", v_excl, 0);
    chk("R8", "drive direction samples", v_dir, 0);
    chk("R9", "short recovery gaps", v_rec, 0);
    chk("R9", "wrong strobe widths", v_low, 0);
    chk("R9", "short setup before strobe", v_setup, 0);

    summary();
    $finish;
  end

endmodule